// File: doc/BRIEF.md
# Hex Text Program Loader

This block rewrites a processor's program memory after the device has been configured. It takes the characters arriving over a serial link as a byte stream and reads them as lines of hexadecimal text. Each completed line becomes one 32-bit word. The word is written to the next program-memory location, starting at word 0. While loading is in progress, the block holds the processor in reset. It also takes over a shared LED bank, where it shows how many words have arrived.

Loader mode is entered only at one moment: the mode button must be held while system reset is released. At the first clock after reset is released, the block samples the button and decides whether to load. Pressing the button at any later time does nothing. Receiving an upper-case `Q` ends the load. The processor is then released and the LEDs go back to the general-purpose output port.

Both data interfaces use valid/ready handshakes. A received byte is consumed in a cycle where `rx_valid` and `rx_ready` are both high. A memory write is transferred in a cycle where `wr_valid` and `wr_ready` are both high. The block raises `wr_valid` one cycle after it accepts the terminator that closes a word. From then until the write is taken, `rx_ready` stays low and `wr_addr` and `wr_data` are held stable. Back-pressure from the memory side therefore stalls the serial byte stream.

Top module: `hex_prog_loader`

## Requirements
- R1: The loader becomes active only if `mode_btn` is high at the first rising clock edge after `rst_n` goes high. A button press at any later time leaves it inactive.
- R2: `cpu_hold`, `loader_active` and `led_sel` are high exactly while the loader is active. They are low in reset.
- R3: While active, the hex digits 0x30-0x39, 0x41-0x46 and 0x61-0x66 each shift their 4-bit value into a 32-bit accumulator from the right. When more than 8 digits arrive, only the last 8 are kept.
- R4: While active, a terminator (0x0D or 0x0A) that follows at least one digit produces one memory write of the accumulated word. The write addresses run consecutively from word 0.
- R5: A terminator with no digit since the previous terminator produces no write, so a CR LF pair yields a single word. Every terminator clears the accumulator.
- R6: Any byte that is neither a digit, a terminator nor 0x51 is consumed and changes neither the word being built nor the output.
- R7: Byte 0x51 (`Q`) ends loading: all three flags fall on the following cycle, and later bytes cause no writes.
- R8: After word DEPTH-1 (8191 by default) the write address wraps to 0. `led_count` shows the number of words written, modulo 2^LED_W.
- R9: Once raised, `wr_valid` stays high with `wr_addr` and `wr_data` unchanged until `wr_ready` is seen. `rx_ready` is low while a write is pending.
- R10: While inactive, received bytes are consumed and no write is ever issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| mode_btn | input | 1 | Loader-entry button, sampled at reset release |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | Received character is present |
| rx_ready | output | 1 | Block can take a character |
| wr_valid | output | 1 | Memory write pending |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 13 | Word address of the write |
| wr_data | output | 32 | Word to write |
| cpu_hold | output | 1 | Hold the processor in reset |
| loader_active | output | 1 | Loader mode indicator |
| led_sel | output | 1 | LED multiplexer select, 1 selects the word count |
| led_count | output | 16 | Count of words written, for the LEDs |

## Verification
The checker enforces the handshake rules on every cycle. It also checks that a write starts only one cycle after an accepted terminator, that the quit byte drops the active flag on the next cycle, that an idle loader never becomes active later, and that no write is started while idle. Other behaviour can only be shown by the bench scenarios, which compare against a character-level model: the word values built from mixed-case digits and junk characters, the single word produced by a CR LF pair, the keeping of only the last eight digits, and the address wrap after 8192 words.

// File: rtl/loader_pkg.sv
package loader_pkg;
  typedef enum logic [1:0] {
    CH_OTHER = 2'd0,
    CH_HEX   = 2'd1,
    CH_EOL   = 2'd2,
    CH_QUIT  = 2'd3
  } ch_kind_t;

  localparam logic [7:0] CODE_CR   = 8'h0D;
  localparam logic [7:0] CODE_LF   = 8'h0A;
  localparam logic [7:0] CODE_QUIT = 8'h51;
endpackage

// File: rtl/ldr_char_decode.sv
module ldr_char_decode
  import loader_pkg::*;
#(
  parameter bit ACCEPT_LOWER = 1'b1
) (
  input  logic [7:0] ch,
  output ch_kind_t   kind,
  output logic [3:0] nib
);
  logic       is_dec, is_up;
  logic       is_low;
  logic [3:0] low_nib;

  assign is_dec = (ch >= 8'h30) && (ch <= 8'h39);
  assign is_up  = (ch >= 8'h41) && (ch <= 8'h46);

  generate
    if (ACCEPT_LOWER) begin : g_lower
      assign is_low  = (ch >= 8'h61) && (ch <= 8'h66);
      assign low_nib = 4'(ch - 8'h57);
    end else begin : g_upper_only
      assign is_low  = 1'b0;
      assign low_nib = 4'd0;
    end
  endgenerate

  always_comb begin
    kind = CH_OTHER;
    nib  = 4'd0;
    if (is_dec) begin
      kind = CH_HEX;
      nib  = ch[3:0];
    end else if (is_up) begin
      kind = CH_HEX;
      nib  = 4'(ch - 8'h37);
    end else if (is_low) begin
      kind = CH_HEX;
      nib  = low_nib;
    end else if (ch == CODE_CR || ch == CODE_LF) begin
      kind = CH_EOL;
    end else if (ch == CODE_QUIT) begin
      kind = CH_QUIT;
    end
  end
endmodule

// File: rtl/ldr_word_accum.sv
module ldr_word_accum #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              clear,
  input  logic [3:0]        nib,
  output logic [WORD_W-1:0] word,
  output logic              have_digit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word       <= '0;
      have_digit <= 1'b0;
    end else if (clear) begin
      word       <= '0;
      have_digit <= 1'b0;
    end else if (shift_en) begin
      word       <= {word[WORD_W-5:0], nib};
      have_digit <= 1'b1;
    end
  end
endmodule

// File: rtl/ldr_ctrl.sv
module ldr_ctrl
  import loader_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8192,
  parameter int LED_W  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_btn,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  ch_kind_t          kind,
  input  logic [WORD_W-1:0] word,
  input  logic              have_digit,
  output logic              shift_en,
  output logic              clear,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              active,
  output logic [LED_W-1:0]  count
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic              first_cyc;
  logic [ADDR_W-1:0] next_addr;
  logic              take, commit;

  assign rx_ready = !wr_valid;
  assign take     = rx_valid && rx_ready && active;
  assign shift_en = take && (kind == CH_HEX);
  assign clear    = take && (kind == CH_EOL);
  assign commit   = clear && have_digit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_cyc <= 1'b1;
      active    <= 1'b0;
      next_addr <= '0;
      count     <= '0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      first_cyc <= 1'b0;
      if (first_cyc) active <= mode_btn;
      else if (take && kind == CH_QUIT) active <= 1'b0;

      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (commit) begin
        wr_valid  <= 1'b1;
        wr_addr   <= next_addr;
        wr_data   <= word;
        next_addr <= (next_addr == LAST_ADDR) ? '0 : next_addr + 1'b1;
        count     <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hex_prog_loader.sv
module hex_prog_loader
  import loader_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8192,
  parameter int LED_W  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_btn,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              cpu_hold,
  output logic              loader_active,
  output logic              led_sel,
  output logic [LED_W-1:0]  led_count
);
  ch_kind_t          kind;
  logic [3:0]        nib;
  logic [WORD_W-1:0] word;
  logic              have_digit, shift_en, clear, active;

  ldr_char_decode #(.ACCEPT_LOWER(1'b1)) u_dec (
    .ch(rx_data), .kind(kind), .nib(nib)
  );

  ldr_word_accum #(.WORD_W(WORD_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .clear(clear),
    .nib(nib), .word(word), .have_digit(have_digit)
  );

  ldr_ctrl #(.WORD_W(WORD_W), .DEPTH(DEPTH), .LED_W(LED_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_btn(mode_btn),
    .rx_valid(rx_valid), .rx_ready(rx_ready),
    .kind(kind), .word(word), .have_digit(have_digit),
    .shift_en(shift_en), .clear(clear),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .active(active), .count(led_count)
  );

  assign cpu_hold      = active;
  assign loader_active = active;
  assign led_sel       = active;
endmodule

// File: rtl/hex_prog_loader_chk.sv
module hex_prog_loader_chk #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        rx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic              loader_active
);
  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R4
  wr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(rx_valid && rx_ready && (rx_data == 8'h0A || rx_data == 8'h0D)));

  // R7
  quit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loader_active && rx_valid && rx_ready && rx_data == 8'h51) |=> !loader_active);

  // R1
  no_late_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !loader_active) |=> !loader_active);

  // R10
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> loader_active);
endmodule

bind hex_prog_loader hex_prog_loader_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .loader_active(loader_active)
);

// File: tb/test_hex_prog_loader.sv
`timescale 1ns/1ps
module test_hex_prog_loader;
  localparam int DEPTH = 8192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_btn = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [12:0] wr_addr;
  logic [31:0] wr_data;
  logic        cpu_hold, loader_active, led_sel;
  logic [15:0] led_count;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit rand_ready = 0;

  logic        m_load = 0;
  logic [31:0] m_acc = 0;
  bit          m_seen = 0;
  int          m_addr = 0;
  int          m_cnt = 0;
  int          exp_addr[$];
  logic [31:0] exp_data[$];

  always #5 clk = ~clk;

  hex_prog_loader i_hex_prog_loader (
    .clk(clk), .rst_n(rst_n), .mode_btn(mode_btn),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_hold(cpu_hold), .loader_active(loader_active),
    .led_sel(led_sel), .led_count(led_count)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int hex_val(input logic [7:0] c);
    if (c >= 8'h30 && c <= 8'h39) return int'(c - 8'h30);
    if (c >= 8'h41 && c <= 8'h46) return int'(c - 8'h37);
    if (c >= 8'h61 && c <= 8'h66) return int'(c - 8'h57);
    return -1;
  endfunction

  function automatic logic [7:0] hex_char(input int i);
    if (i < 10) return 8'(8'h30 + i);
    if (i < 16) return 8'(8'h41 + i - 10);
    return 8'(8'h61 + i - 16);
  endfunction

  function automatic logic [7:0] junk_char(input int i);
    case (i % 6)
      0: return 8'h20;
      1: return 8'h78;
      2: return 8'h47;
      3: return 8'h3A;
      4: return 8'h71;
      default: return 8'h7A;
    endcase
  endfunction

  task automatic model_step(input logic [7:0] c);
    int v;
    if (!m_load) return;
    v = hex_val(c);
    if (v >= 0) begin
      m_acc  = {m_acc[27:0], 4'(v)};
      m_seen = 1;
    end else if (c == 8'h0A || c == 8'h0D) begin
      if (m_seen) begin
        exp_addr.push_back(m_addr);
        exp_data.push_back(m_acc);
        m_addr = (m_addr + 1) % DEPTH;
        m_cnt++;
      end
      m_acc  = 0;
      m_seen = 0;
    end else if (c == 8'h51) begin
      m_load = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] c);
    rx_data  = c;
    rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    model_step(c);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_addr.size() != 0 || wr_valid) && t < 200) begin
      @(negedge clk);
      t++;
    end
    check(exp_addr.size() == 0 && !wr_valid, "R4 drain", 32'(exp_addr.size()), 32'd0);
  endtask

  task automatic do_reset(input bit btn);
    @(negedge clk);
    rst_n = 1'b0;
    mode_btn = btn;
    m_acc = 0; m_seen = 0; m_addr = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_load = btn;
    repeat (2) @(negedge clk);
    mode_btn = 1'b0;
    @(negedge clk);
  endtask

  // write monitor and stream rules
  initial begin
    bit          stall = 0;
    logic [12:0] s_addr = 0;
    logic [31:0] s_data = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (stall)
          check(wr_valid && wr_addr == s_addr && wr_data == s_data,
                "R9 held write", wr_data, s_data);
        if (wr_valid) check(!rx_ready, "R9 rx_ready low", 32'(rx_ready), 32'd0);
        if (wr_valid && wr_ready) begin
          if (exp_addr.size() == 0) begin
            check(1'b0, "R10 unexpected write", 32'(wr_addr), 32'd0);
          end else begin
            int          ea;
            logic [31:0] ed;
            ea = exp_addr.pop_front();
            ed = exp_data.pop_front();
            check(int'(wr_addr) == ea, "R4 R8 address", 32'(wr_addr), 32'(ea));
            check(wr_data == ed, "R3 data", wr_data, ed);
          end
        end
        stall  = wr_valid && !wr_ready;
        s_addr = wr_addr;
        s_data = wr_data;
      end else begin
        stall = 0;
      end
    end
  end

  // memory-side ready
  initial begin
    forever begin
      @(posedge clk);
      #1;
      wr_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  // watchdog
  initial begin
    #(10 * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic flag_check(input bit exp, input string req);
    check(cpu_hold == exp && loader_active == exp && led_sel == exp, req,
          {29'd0, cpu_hold, loader_active, led_sel}, {29'd0, exp, exp, exp});
  endtask

  initial begin
    void'($urandom(32'd1234));
    // reset state
    repeat (2) @(negedge clk);
    flag_check(1'b0, "R2 in reset");
    check(!wr_valid, "R2 no write in reset", 32'(wr_valid), 32'd0);

    // R1/R10: normal boot, later button press ignored
    do_reset(1'b0);
    flag_check(1'b0, "R1 no entry without button");
    mode_btn = 1'b1;
    repeat (3) @(negedge clk);
    mode_btn = 1'b0;
    flag_check(1'b0, "R1 late press ignored");
    send_str("12AB\n34\r\n");
    drain();
    check(led_count == 16'd0, "R10 idle count", 32'(led_count), 32'd0);

    // R1/R2: entry
    do_reset(1'b1);
    flag_check(1'b1, "R1 R2 entry");
    check(led_count == 16'd0, "R8 count start", 32'(led_count), 32'd0);

    // R3 R4 R5: mixed case, CR LF pair
    send_str("DEADbeef\r\n");
    drain();
    check(led_count == 16'd1, "R5 one word for CRLF", 32'(led_count), 32'd1);
    send_str("\n\r\n");
    drain();
    check(led_count == 16'd1, "R5 empty lines", 32'(led_count), 32'd1);
    // R6: junk ignored
    send_str("12 3xg:4z\n");
    // R3: more than eight digits
    send_str("123456789\n");
    drain();
    check(led_count == 16'd3, "R6 R3 count", 32'(led_count), 32'd3);

    // random lines with back-pressure
    rand_ready = 1;
    for (int ln = 0; ln < 300; ln++) begin
      int n = $urandom % 11;
      for (int k = 0; k < n; k++) begin
        if (($urandom % 5) == 0) send_byte(junk_char($urandom % 6));
        else send_byte(hex_char($urandom % 22));
      end
      send_byte((($urandom % 2) == 0) ? 8'h0D : 8'h0A);
    end
    drain();
    check(led_count == 16'(m_cnt), "R8 count after random", 32'(led_count), 32'(m_cnt));

    // R8: wrap
    rand_ready = 0;
    while (m_cnt < DEPTH + 3) send_str("7\n");
    drain();
    check(led_count == 16'(m_cnt), "R8 count after wrap", 32'(led_count), 32'(m_cnt));
    check(m_addr == (m_cnt % DEPTH), "R8 model wrap", 32'(m_addr), 32'(m_cnt % DEPTH));

    // R7: quit
    send_str("AB");
    send_byte(8'h51);
    flag_check(1'b0, "R7 quit clears flags");
    send_str("5\n66\r");
    drain();
    check(led_count == 16'(m_cnt), "R7 no writes after quit", 32'(led_count), 32'(m_cnt));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule